// File: doc/BRIEF.md
# Three-Wire Addressed Register Loader

This block takes configuration words from a slow three-wire serial port (a data line, a serial clock and a load strobe) and places them into one of four staged registers. The three wires are first brought into the system clock domain. Each rising edge of the serial clock, as seen in that domain, shifts the data line into an 18-bit shift register. The oldest bit ends up at the top, so a word is sent most significant bit first.

When the load strobe rises, the two bits that arrived last are read as a slot address. The 16 bits sent before them go into that slot's holding register, and the slot is marked as having an update waiting. Each slot feeds a downstream divide counter. The waiting value moves into the slot's active register only when that counter reports terminal count. A divide ratio therefore never changes in the middle of a count cycle.

Top module: `cfg_serial_loader`

## Requirements
- R1: After synchronous reset every holding register, every active register and every pending flag read zero.
- R2: A word is 18 bits sent most significant bit first, each bit taken on a rising serial clock edge; the first 16 bits form the payload (payload bit 15 first) and the last 2 bits form the slot address (address bit 1 first).
- R3: A rising edge on the load strobe copies the payload into the holding register of the addressed slot only; the other three holding registers keep their values.
- R4: A load sets the pending flag of the addressed slot (pending_o bit equal to the slot number).
- R5: A slot's active register takes its holding value only in a cycle where its terminal count input is high and its pending flag is set; that transfer clears the pending flag, and a terminal count on another slot leaves it pending.
- R6: A terminal count on a slot with no pending update leaves its active register unchanged.
- R7: A second load to a slot before its transfer replaces the waiting value, and only the latest value reaches the active register.
- R8: When more than 18 bits are shifted before a load, only the last 18 received are used.
- R9: Shifting bits without a load strobe edge changes no holding register, active register or pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous to clk |
| ser_data_i | input | 1 | Serial data, asynchronous to clk |
| ser_load_i | input | 1 | Load strobe, asynchronous to clk |
| tc_i | input | 4 | Terminal count per slot, one bit per slot, synchronous to clk |
| hold_o | output | 64 | Holding registers, slot n in bits 16n+15..16n |
| active_o | output | 64 | Active registers, slot n in bits 16n+15..16n |
| pending_o | output | 4 | Pending update flag per slot |

## Verification
The checks assume that every level on the three serial wires stays steady for more than the synchronizer depth plus one system cycles. They also assume that the data line is already settled when the serial clock rises, so that data and clock cross with the same latency. The stimulus holds data for four cycles before each serial clock rise and keeps each serial clock phase and each load pulse four cycles long. Terminal count is driven as a one-cycle synchronous pulse, changed only on falling clock edges.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    localparam int unsigned FRAME_BITS  = 18;
    localparam int unsigned SLOT_ABITS  = 2;
    localparam int unsigned WORD_BITS   = FRAME_BITS - SLOT_ABITS;
    localparam int unsigned SLOT_COUNT  = 1 << SLOT_ABITS;
    localparam int unsigned SYNC_DEPTH  = 2;

    // Position of each serial wire inside the synchronized bundle
    typedef enum int unsigned {
        WIRE_DATA = 0,
        WIRE_CLK  = 1,
        WIRE_LOAD = 2
    } wire_idx_e;

    localparam int unsigned WIRE_COUNT = 3;

    // Update state of one staged slot
    typedef enum logic {
        SLOT_IDLE    = 1'b0,
        SLOT_WAITING = 1'b1
    } slot_state_e;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
    parameter int unsigned SR_W = 18
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sclk_lvl_i,
    input  logic            sdat_lvl_i,
    output logic [SR_W-1:0] frame_o
);

    logic            sclk_prev_q;
    logic            shift_en;
    logic [SR_W-1:0] sr_q;

    assign shift_en = sclk_lvl_i & ~sclk_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev_q <= 1'b0;
            sr_q        <= '0;
        end else begin
            sclk_prev_q <= sclk_lvl_i;
            if (shift_en) sr_q <= {sr_q[SR_W-2:0], sdat_lvl_i};
        end
    end

    assign frame_o = sr_q;

    // R2: the newest bit lands at the bottom of the register
    assert_shift_lsb_R2: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> sr_q[0] == $past(sdat_lvl_i));

    // R2: older bits move up one place on each edge
    assert_shift_up_R2: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> sr_q[SR_W-1:1] == $past(sr_q[SR_W-2:0]));

    // R9: without a serial clock rise the register is frozen
    assert_sr_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(sr_q));

endmodule

// File: rtl/cfg_slot.sv
module cfg_slot
    import cfg_loader_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [DATA_W-1:0] payload_i,
    input  logic              tc_i,
    output logic [DATA_W-1:0] hold_o,
    output logic [DATA_W-1:0] active_o,
    output logic              pending_o
);

    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] active_q;
    slot_state_e       state_q;

    // A load in the same cycle as terminal count wins: the new word waits
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= '0;
            active_q <= '0;
            state_q  <= SLOT_IDLE;
        end else if (load_i) begin
            hold_q  <= payload_i;
            state_q <= SLOT_WAITING;
        end else if (state_q == SLOT_WAITING && tc_i) begin
            active_q <= hold_q;
            state_q  <= SLOT_IDLE;
        end
    end

    assign hold_o    = hold_q;
    assign active_o  = active_q;
    assign pending_o = (state_q == SLOT_WAITING);

    assert_load_marks_R4: assert property (@(posedge clk) disable iff (rst)
        load_i |=> pending_o && hold_q == $past(payload_i));

    assert_active_on_tc_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(active_q) |-> $past(tc_i) && $past(pending_o));

    assert_pending_drop_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(pending_o) |-> $past(tc_i) && active_q == $past(hold_q));

    assert_idle_tc_R6: assert property (@(posedge clk) disable iff (rst)
        (tc_i && !pending_o) |=> $stable(active_q));

    assert_hold_only_on_load_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(hold_q) |-> $past(load_i));

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfg_loader_pkg::*;
#(
    parameter int unsigned SR_W       = FRAME_BITS,
    parameter int unsigned ADDR_W     = SLOT_ABITS,
    parameter int unsigned SYNC_STAGE = SYNC_DEPTH,
    localparam int unsigned DATA_W    = SR_W - ADDR_W,
    localparam int unsigned SLOTS     = 1 << ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ser_clk_i,
    input  logic                    ser_data_i,
    input  logic                    ser_load_i,
    input  logic [SLOTS-1:0]        tc_i,
    output logic [SLOTS*DATA_W-1:0] hold_o,
    output logic [SLOTS*DATA_W-1:0] active_o,
    output logic [SLOTS-1:0]        pending_o
);

    logic [WIRE_COUNT-1:0] wires_raw;
    logic [WIRE_COUNT-1:0] wires_lvl;
    logic [SR_W-1:0]       frame;
    logic [ADDR_W-1:0]     frame_addr;
    logic [DATA_W-1:0]     frame_word;
    logic                  load_prev_q;
    logic                  load_rise;
    logic [SLOTS-1:0]      load_vec;

    always_comb begin
        wires_raw            = '0;
        wires_raw[WIRE_DATA] = ser_data_i;
        wires_raw[WIRE_CLK]  = ser_clk_i;
        wires_raw[WIRE_LOAD] = ser_load_i;
    end

    cfg_sync #(
        .WIDTH  (WIRE_COUNT),
        .STAGES (SYNC_STAGE)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (wires_raw),
        .sync_o  (wires_lvl)
    );

    cfg_shifter #(
        .SR_W (SR_W)
    ) u_shift (
        .clk        (clk),
        .rst        (rst),
        .sclk_lvl_i (wires_lvl[WIRE_CLK]),
        .sdat_lvl_i (wires_lvl[WIRE_DATA]),
        .frame_o    (frame)
    );

    // Address rides in the two bits shifted last
    assign frame_addr = frame[ADDR_W-1:0];
    assign frame_word = frame[SR_W-1:ADDR_W];

    always_ff @(posedge clk) begin
        if (rst) load_prev_q <= 1'b0;
        else     load_prev_q <= wires_lvl[WIRE_LOAD];
    end

    assign load_rise = wires_lvl[WIRE_LOAD] & ~load_prev_q;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign load_vec[s] = load_rise && (frame_addr == ADDR_W'(s));

        cfg_slot #(
            .DATA_W (DATA_W)
        ) u_slot (
            .clk       (clk),
            .rst       (rst),
            .load_i    (load_vec[s]),
            .payload_i (frame_word),
            .tc_i      (tc_i[s]),
            .hold_o    (hold_o[s*DATA_W +: DATA_W]),
            .active_o  (active_o[s*DATA_W +: DATA_W]),
            .pending_o (pending_o[s])
        );
    end

    // R3: one strobe edge reaches exactly one slot
    assert_one_slot_R3: assert property (@(posedge clk) disable iff (rst)
        load_rise |-> $countones(load_vec) == 1);

    assert_no_load_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !load_rise |=> $stable(pending_o) || $past(|tc_i));

    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
        load_rise |=> !load_rise);

endmodule

// File: tb/cfg_serial_loader_test.sv
module cfg_serial_loader_test;

    localparam int NS = 4;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ser_clk_i = 1'b0;
    logic          ser_data_i = 1'b0;
    logic          ser_load_i = 1'b0;
    logic [NS-1:0] tc_i = '0;
    logic [NS*DW-1:0] hold_o;
    logic [NS*DW-1:0] active_o;
    logic [NS-1:0]    pending_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [DW-1:0] m_hold [NS];
    logic [DW-1:0] m_act  [NS];
    logic [NS-1:0] m_pend;

    // Vector table: {payload, slot}
    localparam logic [17:0] VEC [6] = '{
        {16'hA5C3, 2'd0}, {16'h1234, 2'd1}, {16'hFFFF, 2'd2},
        {16'h0001, 2'd3}, {16'h8000, 2'd1}, {16'h5A5A, 2'd0}
    };

    always #2 clk = ~clk;

    cfg_serial_loader uut (
        .clk        (clk),
        .rst        (rst),
        .ser_clk_i  (ser_clk_i),
        .ser_data_i (ser_data_i),
        .ser_load_i (ser_load_i),
        .tc_i       (tc_i),
        .hold_o     (hold_o),
        .active_o   (active_o),
        .pending_o  (pending_o)
    );

    function automatic logic [NS*DW-1:0] flat(input logic [DW-1:0] a [NS]);
        logic [NS*DW-1:0] r;
        for (int i = 0; i < NS; i++) r[i*DW +: DW] = a[i];
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check({req, " hold"}, hold_o, flat(m_hold));
        check({req, " active"}, active_o, flat(m_act));
        check({req, " pending"}, 64'(pending_o), 64'(m_pend));
    endtask

    task automatic ser_bit(input logic b);
        ser_data_i = b;
        repeat (4) @(negedge clk);
        ser_clk_i = 1'b1;
        repeat (4) @(negedge clk);
        ser_clk_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) ser_bit(bits[i]);
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_load();
        ser_load_i = 1'b1;
        repeat (4) @(negedge clk);
        ser_load_i = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse_tc(input logic [NS-1:0] m);
        tc_i = m;
        @(negedge clk);
        tc_i = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic model_load(input logic [17:0] w);
        m_hold[w[1:0]] = w[17:2];
        m_pend[w[1:0]] = 1'b1;
    endtask

    task automatic model_tc(input logic [NS-1:0] m);
        for (int s = 0; s < NS; s++)
            if (m[s] && m_pend[s]) begin
                m_act[s]  = m_hold[s];
                m_pend[s] = 1'b0;
            end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < NS; s++) begin
            m_hold[s] = '0;
            m_act[s]  = '0;
        end
        m_pend = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check_all("R1 reset");

        // R6: terminal count on every slot with nothing pending
        pulse_tc('1);
        check_all("R6 idle tc");

        // Table walk: R2 framing, R3 addressing, R4 pending, R5 transfer
        for (int v = 0; v < 6; v++) begin
            send_bits(32'(VEC[v]), 18);
            pulse_load();
            model_load(VEC[v]);
            check_all("R2 R3 R4 load");
            pulse_tc(NS'(1) << VEC[v][1:0]);
            model_tc(NS'(1) << VEC[v][1:0]);
            check_all("R5 transfer");
        end

        // R5: terminal count on another slot leaves a waiting update alone
        send_bits({14'd0, 16'h0F0F, 2'd1}, 18);
        pulse_load();
        model_load({16'h0F0F, 2'd1});
        pulse_tc(4'b0001);
        model_tc(4'b0001);
        check_all("R5 other slot tc");
        pulse_tc(4'b0010);
        model_tc(4'b0010);
        check_all("R5 own tc");

        // R7: two loads before the transfer
        send_bits({14'd0, 16'h1111, 2'd2}, 18);
        pulse_load();
        model_load({16'h1111, 2'd2});
        send_bits({14'd0, 16'h2222, 2'd2}, 18);
        pulse_load();
        model_load({16'h2222, 2'd2});
        check_all("R7 overwrite hold");
        pulse_tc(4'b0100);
        model_tc(4'b0100);
        check_all("R7 latest applied");

        // R8: 22 bits, the first four are discarded
        send_bits({10'd0, 4'b1011, 16'hC0DE, 2'd3}, 22);
        pulse_load();
        model_load({16'hC0DE, 2'd3});
        check_all("R8 long frame");

        // R9: shifting alone changes nothing visible
        send_bits({14'd0, 16'hBEEF, 2'd0}, 18);
        check_all("R9 shift only");
        pulse_load();
        model_load({16'hBEEF, 2'd0});
        check_all("R9 then load");
        pulse_tc('1);
        model_tc('1);
        check_all("R5 all tc");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule